// File: doc/BRIEF.md
# Scrolling Row Scan Mapper

This block sequences the row scan of a multiplexed matrix display. Each pulse on `row_tick` moves the scan to the next slot of the frame. For every slot the block reports two things: the display memory row to fetch and the row-driver output to energise. Scrolling never touches memory contents. It only changes which memory row feeds which driver. The first memory row fetched in a frame feeds the first driver, and the rest follow in fetch order.

The frame length follows a selectable multiplex rate: 65, 49 or 33 active rows. The driver order can run forward or be flipped. When icon mode is on, the last slot of the frame reads a fixed icon row, and the scrolled graphic area shrinks by one row.

At each frame start the block latches the scroll pointer, the rate, the direction and the icon mode together, so a change made mid-frame cannot tear the image.

The control is a three-state machine:
- `ST_IDLE` is held after reset. The first tick moves it to `ST_SCAN`, and that tick starts a frame.
- In `ST_SCAN`, a tick advances to the next graphic slot, stays in `ST_SCAN`, or ends the frame and starts a new one.
- When icon mode is latched, the tick into the last slot moves `ST_SCAN` to `ST_ICON`.
- A tick in `ST_ICON` always starts a new frame and returns to `ST_SCAN`.

Top module: `scroll_scan_mapper`

## Requirements
- R1: While reset is asserted, and after reset until the first `row_tick`, `mem_row`, `drv_idx` and `frame_start` are all 0.
- R2: The first tick after reset starts a frame, and so does the tick that follows the last slot of a frame. The slot then becomes 0, and `frame_start` is 1 exactly while slot 0 is presented.
- R3: `mux_sel` sets the number of slots N per frame: 0 gives 65, 1 gives 49, 2 gives 33 and 3 gives 65.
- R4: Let G be the number of graphic rows (N, or N-1 in icon mode) and P the latched scroll pointer. For graphic slot i, `mem_row` = (i + P) mod G, with P taken modulo G.
- R5: With `dir_rev`=0, `drv_idx` equals the slot number i. With `dir_rev`=1, `drv_idx` = N-1-i.
- R6: With `icon_en`=1, the last slot (i = N-1) reads memory row 64, and the graphic slots wrap modulo N-1.
- R7: Changes to `scroll_ptr`, `mux_sel`, `dir_rev` or `icon_en` during a frame have no effect until the next frame start.
- R8: The outputs change only on a clock edge where `row_tick` is 1. Without a tick they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_tick | input | 1 | Advance to the next scan slot |
| scroll_ptr | input | 7 | Scroll start row |
| mux_sel | input | 2 | Multiplex rate select |
| dir_rev | input | 1 | 1 = reversed driver order |
| icon_en | input | 1 | 1 = last slot is the icon row |
| mem_row | output | 7 | Memory row to read for this slot |
| drv_idx | output | 7 | Row driver to activate |
| frame_start | output | 1 | High while slot 0 is presented |

## Verification
If the slot counter or the latched frame setup is corrupted, the error shows on the very next tick. `drv_idx` leaves the expected forward or reversed sequence, or `frame_start` appears at the wrong slot. A memory-row counter that drifts shows as a skipped or repeated row. A missed wrap shows as a row at or past G on the same tick. An icon decision that goes wrong shows at the last slot of the frame, as something other than row 64 or as an unwanted row 64. A pointer latched mid-frame shows on the tick right after the input change.

// File: rtl/scan_map_pkg.sv
package scan_map_pkg;
    localparam int ROW_W     = 7;
    localparam int FULL_ROWS = 65;
    localparam int MID_ROWS  = 49;
    localparam int LOW_ROWS  = 33;
    localparam int ICON_ROW  = 64;
    // worst-case subtractions needed to fold a pointer below the graphic row count
    localparam int SUB_STEPS = (2 ** ROW_W) / (LOW_ROWS - 1) + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_ICON = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic [ROW_W-1:0] rows;   // slots per frame
        logic [ROW_W-1:0] gfx;    // scrolled graphic rows
        logic [ROW_W-1:0] start;  // pointer folded modulo gfx
        logic             rev;
        logic             icon;
    } frame_cfg_t;
endpackage

// File: rtl/scan_map_geom.sv
module scan_map_geom
    import scan_map_pkg::*;
(
    input  logic [1:0]       mux_sel,
    input  logic [ROW_W-1:0] scroll_ptr,
    input  logic             dir_rev,
    input  logic             icon_en,
    output frame_cfg_t       cfg
);
    logic [ROW_W-1:0] rows_w;
    logic [ROW_W-1:0] gfx_w;
    logic [ROW_W-1:0] rem_w;

    always_comb begin
        unique case (mux_sel)
            2'd1:    rows_w = ROW_W'(MID_ROWS);
            2'd2:    rows_w = ROW_W'(LOW_ROWS);
            default: rows_w = ROW_W'(FULL_ROWS);
        endcase
        gfx_w = icon_en ? (rows_w - ROW_W'(1)) : rows_w;
        rem_w = scroll_ptr;
        for (int k = 0; k < SUB_STEPS; k++) begin
            if (rem_w >= gfx_w) rem_w = rem_w - gfx_w;
        end
    end

    assign cfg = '{rows: rows_w, gfx: gfx_w, start: rem_w, rev: dir_rev, icon: icon_en};
endmodule

// File: rtl/scan_map_seq.sv
module scan_map_seq
    import scan_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_tick,
    input  frame_cfg_t       cfg_in,
    output logic [ROW_W-1:0] mem_row,
    output logic [ROW_W-1:0] drv_idx,
    output logic             frame_start
);
    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

    scan_state_e      state_q, state_d;
    logic [ROW_W-1:0] slot_q, slot_d;
    frame_cfg_t       cfg_q, cfg_d;
    logic             new_frame;
    logic [ROW_W-1:0] mem_d, drv_d;

    // next-state process
    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        cfg_d     = cfg_q;
        new_frame = 1'b0;
        if (row_tick) begin
            unique case (state_q)
                ST_IDLE: new_frame = 1'b1;
                ST_SCAN: new_frame = (slot_q == cfg_q.rows - ONE);
                ST_ICON: new_frame = 1'b1;
                default: new_frame = 1'b1;
            endcase
            if (new_frame) begin
                cfg_d   = cfg_in;
                slot_d  = '0;
                state_d = ST_SCAN;
            end else begin
                slot_d  = slot_q + ONE;
                state_d = (cfg_q.icon && (slot_d == cfg_q.rows - ONE)) ? ST_ICON : ST_SCAN;
            end
        end
    end

    // output values for the slot being entered
    always_comb begin
        if (new_frame)                mem_d = cfg_in.start;
        else if (state_d == ST_ICON)  mem_d = ROW_W'(ICON_ROW);
        else if (mem_row + ONE == cfg_q.gfx) mem_d = '0;
        else                          mem_d = mem_row + ONE;
        drv_d = cfg_d.rev ? (cfg_d.rows - ONE - slot_d) : slot_d;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            cfg_q   <= cfg_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_row     <= '0;
            drv_idx     <= '0;
            frame_start <= 1'b0;
        end else if (row_tick) begin
            mem_row     <= mem_d;
            drv_idx     <= drv_d;
            frame_start <= new_frame;
        end
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> (mem_row == '0 && drv_idx == '0 && !frame_start));
    p_start_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot_q == '0 && state_q == ST_SCAN));
    p_drv_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |-> drv_idx < cfg_q.rows);
    p_mem_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SCAN |-> mem_row < cfg_q.gfx);
    p_icon_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ICON |-> (mem_row == ROW_W'(ICON_ROW) && cfg_q.icon));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !row_tick |=> ($stable(mem_row) && $stable(drv_idx) && $stable(frame_start)));
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tick && !frame_start && state_q == ST_SCAN && slot_q != cfg_q.rows - ONE) |=> $stable(cfg_q));
endmodule

// File: rtl/scroll_scan_mapper.sv
module scroll_scan_mapper
    import scan_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_tick,
    input  logic [ROW_W-1:0] scroll_ptr,
    input  logic [1:0]       mux_sel,
    input  logic             dir_rev,
    input  logic             icon_en,
    output logic [ROW_W-1:0] mem_row,
    output logic [ROW_W-1:0] drv_idx,
    output logic             frame_start
);
    frame_cfg_t next_cfg;

    scan_map_geom u_geom (
        .mux_sel    (mux_sel),
        .scroll_ptr (scroll_ptr),
        .dir_rev    (dir_rev),
        .icon_en    (icon_en),
        .cfg        (next_cfg)
    );

    scan_map_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_tick    (row_tick),
        .cfg_in      (next_cfg),
        .mem_row     (mem_row),
        .drv_idx     (drv_idx),
        .frame_start (frame_start)
    );
endmodule

// File: tb/scroll_scan_mapper_test.sv
module scroll_scan_mapper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_tick = 1'b0;
    logic [6:0] scroll_ptr = '0;
    logic [1:0] mux_sel = '0;
    logic       dir_rev = 1'b0;
    logic       icon_en = 1'b0;
    logic [6:0] mem_row, drv_idx;
    logic       frame_start;

    scroll_scan_mapper uut (
        .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .scroll_ptr(scroll_ptr),
        .mux_sel(mux_sel), .dir_rev(dir_rev), .icon_en(icon_en),
        .mem_row(mem_row), .drv_idx(drv_idx), .frame_start(frame_start)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    mem;
        int    drv;
        int    fs;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic tick_seen = 1'b0;

    // reference model state, latched at frame start
    int m_slot = 0, m_n = 0, m_g = 0, m_ptr = 0;
    bit m_rev = 0, m_started = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(string tag);
        exp_t e;
        @(negedge clk);
        if (!m_started || m_slot == m_n - 1) begin
            m_n = (mux_sel == 2'd1) ? 49 : (mux_sel == 2'd2) ? 33 : 65;
            m_g = icon_en ? m_n - 1 : m_n;
            m_rev = dir_rev;
            m_ptr = int'(scroll_ptr);
            m_slot = 0;
            m_started = 1;
        end else begin
            m_slot++;
        end
        e.mem = (m_slot < m_g) ? (m_slot + m_ptr) % m_g : 64;
        e.drv = m_rev ? (m_n - 1 - m_slot) : m_slot;
        e.fs  = (m_slot == 0) ? 1 : 0;
        e.tag = tag;
        exp_q.push_back(e);
        last_exp = e;
        row_tick = 1'b1;
        @(negedge clk);
        row_tick = 1'b0;
    endtask

    task automatic ticks(int n, string tag);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    always @(posedge clk) tick_seen <= row_tick;

    // monitor: compare after each tick
    always @(negedge clk) begin
        if (rst_n && tick_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2 unexpected result: actual %0d expected none", mem_row);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "mem_row", int'(mem_row), e.mem);
                chk(e.tag, "drv_idx", int'(drv_idx), e.drv);
                chk(e.tag, "frame_start", int'(frame_start), e.fs);
            end
        end
    end

    task automatic idle_hold(int n);
        repeat (n) @(negedge clk);
        chk("R8", "hold mem_row", int'(mem_row), last_exp.mem);
        chk("R8", "hold drv_idx", int'(drv_idx), last_exp.drv);
        chk("R8", "hold frame_start", int'(frame_start), last_exp.fs);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset mem_row", int'(mem_row), 0);
        chk("R1", "reset drv_idx", int'(drv_idx), 0);
        chk("R1", "reset frame_start", int'(frame_start), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "idle mem_row", int'(mem_row), 0);
        chk("R1", "idle drv_idx", int'(drv_idx), 0);
        chk("R1", "idle frame_start", int'(frame_start), 0);

        // 65 rows, no scroll, forward drivers
        ticks(65, "R2 R3 R4 R5");

        // 49 rows, reversed, pointer 40; inputs change mid-frame
        mux_sel = 2'd1; scroll_ptr = 7'd40; dir_rev = 1'b1;
        ticks(10, "R3 R4 R5");
        scroll_ptr = 7'd5; mux_sel = 2'd2; dir_rev = 1'b0; icon_en = 1'b1;
        ticks(20, "R7");
        idle_hold(6);
        ticks(19, "R7");

        // 33 rows with icon, pointer folds 100 mod 32 = 4
        scroll_ptr = 7'd100;
        ticks(33, "R4 R6");

        // 65 rows via code 3, icon, reversed, pointer 64 mod 64 = 0
        mux_sel = 2'd3; dir_rev = 1'b1; scroll_ptr = 7'd64;
        ticks(65, "R3 R5 R6");

        // next frame starts after last slot
        mux_sel = 2'd0; icon_en = 1'b0; dir_rev = 1'b0; scroll_ptr = 7'd7;
        ticks(3, "R2 R4");
        idle_hold(3);
        chk("R2", "pending results", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule